// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block produces an active-high system reset from two request sources. One is a push-button line that may be wired straight from a mechanical switch. The other is a single digital flag from a supply comparator that reads high while the supply is under its trip level. The button line is first passed through a two-flop synchronizer. A debouncer then accepts a new level only after that level has held for a set number of clocks, so contact bounce never reaches the reset output.

Reset is held for as long as either request is active. When both requests have gone away, reset is held for a further stretch time counted in clocks, and only then released. A request that returns during the stretch starts the full stretch again. The block's own asynchronous initialization input also raises reset. The first stretch period then runs before the first release. The debounce window and the stretch time are parameters (`DEBOUNCE_CYCLES`, `STRETCH_CYCLES`).

Top module: `supv_reset_gen`

## Requirements
- R1: While `arstN` is low, `sysRst` is 1. After `arstN` rises with no request active, `sysRst` stays 1 and falls on the `STRETCH_CYCLES`-th rising clock edge after the release.
- R2: A high pulse on `btnRaw` that is sampled high on fewer than `DEBOUNCE_CYCLES` consecutive rising edges has no effect on `sysRst`.
- R3: From the released state, if `btnRaw` is sampled high on edges 1..L with L >= `DEBOUNCE_CYCLES`, `sysRst` rises on edge `DEBOUNCE_CYCLES`+3.
- R4: After such a press of length L, `sysRst` falls on edge L+`DEBOUNCE_CYCLES`+3+`STRETCH_CYCLES`, counted from the first edge that sampled the press.
- R5: A rising edge that samples `supplyLow` high makes `sysRst` 1 after that edge.
- R6: Once `supplyLow` goes low and no other request is active, `sysRst` falls on the (`STRETCH_CYCLES`+1)-th rising edge that samples `supplyLow` low. The internal stretch count never exceeds `STRETCH_CYCLES`-1.
- R7: `sysRst` stays 1 while either request is active. With overlapping requests, the release time is set by whichever request clears last.
- R8: A request that returns while the stretch is running restarts it. The release then follows the timing of R6 or R4, measured from the later request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| arstN | input | 1 | Asynchronous initialization, active low |
| btnRaw | input | 1 | Raw push-button level, active high, idles low |
| supplyLow | input | 1 | Supply comparator flag, high while supply is under threshold |
| sysRst | output | 1 | System reset, active high |

## Verification
A fault in the debouncer state changes the latency at the ports. The rise after a press lands on some edge other than `DEBOUNCE_CYCLES`+3, or a pulse one clock shorter than the window raises reset. Either shows within about ten clocks of the press. A wrong stretch count or a missed restart moves the falling edge of `sysRst` by at least one clock. It is therefore visible on the first release after the fault, `STRETCH_CYCLES` edges later. The sweeps cover press lengths on both sides of the debounce window and every restart offset inside the stretch. This pins each edge exactly.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef enum logic [1:0] {
    ST_HOLD    = 2'd0,
    ST_STRETCH = 2'd1,
    ST_RUN     = 2'd2
  } supv_state_t;

  typedef struct packed {
    logic clrStretch;
    logic incStretch;
  } supv_strobe_t;

endpackage

// File: rtl/supv_datapath.sv
module supv_datapath
  import supv_pkg::*;
#(
  parameter int DEBOUNCE_CYCLES = 4,
  parameter int STRETCH_CYCLES  = 8,
  parameter int SYNC_STAGES     = 2
) (
  input  logic                                  clk,
  input  logic                                  arstN,
  input  logic                                  btnRaw,
  input  logic                                  supplyLow,
  input  supv_strobe_t                          strobes,
  output logic                                  srcActive,
  output logic                                  stretchDone,
  output logic                                  btnStable,
  output logic [$clog2(STRETCH_CYCLES+1)-1:0]   stretchCnt
);
  localparam int DB_W = $clog2(DEBOUNCE_CYCLES + 1);
  localparam int ST_W = $clog2(STRETCH_CYCLES + 1);
  localparam logic [DB_W-1:0] DB_LAST = DB_W'(DEBOUNCE_CYCLES - 1);
  localparam logic [ST_W-1:0] ST_LAST = ST_W'(STRETCH_CYCLES - 1);

  // synchronizer chain for the asynchronous button level
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   btnSync;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge arstN) begin
        if (!arstN) syncQ <= '0;
        else        syncQ <= btnRaw;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge arstN) begin
        if (!arstN) syncQ <= '0;
        else        syncQ <= {syncQ[SYNC_STAGES-2:0], btnRaw};
      end
    end
  endgenerate

  assign btnSync = syncQ[SYNC_STAGES-1];

  // debouncer: a differing level must persist for DEBOUNCE_CYCLES edges
  logic [DB_W-1:0] dbCnt;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      btnStable <= 1'b0;
      dbCnt     <= '0;
    end else if (btnSync == btnStable) begin
      dbCnt <= '0;
    end else if (dbCnt == DB_LAST) begin
      btnStable <= btnSync;
      dbCnt     <= '0;
    end else begin
      dbCnt <= dbCnt + 1'b1;
    end
  end

  // stretch counter driven by control strobes
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)                  stretchCnt <= '0;
    else if (strobes.clrStretch) stretchCnt <= '0;
    else if (strobes.incStretch) stretchCnt <= stretchCnt + 1'b1;
  end

  assign stretchDone = (stretchCnt == ST_LAST);
  assign srcActive   = btnStable | supplyLow;

endmodule

// File: rtl/supv_ctrl.sv
module supv_ctrl
  import supv_pkg::*;
(
  input  logic         clk,
  input  logic         arstN,
  input  logic         srcActive,
  input  logic         stretchDone,
  output supv_strobe_t strobes,
  output logic         rstOut
);
  supv_state_t state, stateNext;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) state <= ST_STRETCH;   // power-up runs a full stretch
    else        state <= stateNext;
  end

  always_comb begin
    stateNext          = state;
    strobes.clrStretch = 1'b0;
    strobes.incStretch = 1'b0;
    if (srcActive) begin
      stateNext          = ST_HOLD;
      strobes.clrStretch = 1'b1;
    end else begin
      unique case (state)
        ST_HOLD: begin
          stateNext          = ST_STRETCH;
          strobes.clrStretch = 1'b1;
        end
        ST_STRETCH: begin
          if (stretchDone) stateNext          = ST_RUN;
          else             strobes.incStretch = 1'b1;
        end
        ST_RUN:  stateNext = ST_RUN;
        default: stateNext = ST_HOLD;
      endcase
    end
  end

  assign rstOut = (state != ST_RUN);

endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
  import supv_pkg::*;
#(
  parameter int DEBOUNCE_CYCLES = 4,
  parameter int STRETCH_CYCLES  = 8
) (
  input  logic clk,
  input  logic arstN,
  input  logic btnRaw,
  input  logic supplyLow,
  output logic sysRst
);
  localparam int ST_W = $clog2(STRETCH_CYCLES + 1);

  supv_strobe_t    strobes;
  logic            srcActive;
  logic            stretchDone;
  logic            btnStable;
  logic [ST_W-1:0] stretchCnt;

  supv_datapath #(
    .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES),
    .STRETCH_CYCLES (STRETCH_CYCLES),
    .SYNC_STAGES    (2)
  ) uDp (
    .clk        (clk),
    .arstN      (arstN),
    .btnRaw     (btnRaw),
    .supplyLow  (supplyLow),
    .strobes    (strobes),
    .srcActive  (srcActive),
    .stretchDone(stretchDone),
    .btnStable  (btnStable),
    .stretchCnt (stretchCnt)
  );

  supv_ctrl uCtrl (
    .clk        (clk),
    .arstN      (arstN),
    .srcActive  (srcActive),
    .stretchDone(stretchDone),
    .strobes    (strobes),
    .rstOut     (sysRst)
  );

endmodule

// File: rtl/supv_reset_checker.sv
module supv_reset_checker #(
  parameter int STRETCH_CYCLES = 8
) (
  input logic                                clk,
  input logic                                arstN,
  input logic                                supplyLow,
  input logic                                sysRst,
  input logic                                btnStable,
  input logic [$clog2(STRETCH_CYCLES+1)-1:0] stretchCnt
);
  localparam int ST_W = $clog2(STRETCH_CYCLES + 1);

  p_supply_forces_r5: assert property (@(posedge clk) disable iff (!arstN)
    supplyLow |=> sysRst);

  p_button_holds_r3: assert property (@(posedge clk) disable iff (!arstN)
    btnStable |=> sysRst);

  p_fall_after_stretch_r6: assert property (@(posedge clk) disable iff (!arstN)
    $fell(sysRst) |-> ($past(stretchCnt) == ST_W'(STRETCH_CYCLES - 1)));

  p_fall_quiet_r7: assert property (@(posedge clk) disable iff (!arstN)
    $fell(sysRst) |-> (!$past(supplyLow) && !$past(btnStable)));

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!arstN)
    stretchCnt <= ST_W'(STRETCH_CYCLES - 1));

endmodule

bind supv_reset_gen supv_reset_checker #(
  .STRETCH_CYCLES(STRETCH_CYCLES)
) uChk (
  .clk       (clk),
  .arstN     (arstN),
  .supplyLow (supplyLow),
  .sysRst    (sysRst),
  .btnStable (btnStable),
  .stretchCnt(stretchCnt)
);

// File: tb/supv_reset_gen_test.sv
module supv_reset_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int DB = 4;
  localparam int ST = 8;

  logic clk = 1'b0;
  logic arstN = 1'b0;
  logic btnRaw = 1'b0;
  logic supplyLow = 1'b0;
  logic sysRst;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  supv_reset_gen #(.DEBOUNCE_CYCLES(DB), .STRETCH_CYCLES(ST)) uut (
    .clk(clk), .arstN(arstN), .btnRaw(btnRaw), .supplyLow(supplyLow), .sysRst(sysRst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive inputs per edge index t (1-based) from windows and record the first
  // rising edge of sysRst and the first fall after it (0 = never).
  task automatic runPattern(input int bFrom, input int bTo,
                            input int s1From, input int s1To,
                            input int s2From, input int s2To,
                            input int n, output int riseAt, output int fallAt);
    riseAt = 0;
    fallAt = 0;
    for (int t = 1; t <= n; t++) begin
      btnRaw    = (t >= bFrom && t <= bTo);
      supplyLow = (t >= s1From && t <= s1To) || (t >= s2From && t <= s2To);
      tick(1);
      if (riseAt == 0 && sysRst) riseAt = t;
      else if (riseAt != 0 && fallAt == 0 && !sysRst) fallAt = t;
    end
    btnRaw = 1'b0;
    supplyLow = 1'b0;
    tick(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int riseAt, fallAt, cnt;
    // R1: reset state and power-up stretch
    tick(3);
    check("R1 reset held during init", int'(sysRst), 1);
    arstN = 1'b1;
    cnt = 0;
    while (sysRst && cnt < 100) begin
      tick(1);
      cnt++;
    end
    check("R1 power-up release edge", cnt, ST);
    tick(3);
    check("R1 stays released", int'(sysRst), 0);

    // R5/R6: supply pulses of several widths
    for (int w = 1; w <= 4; w++) begin
      runPattern(0, -1, 1, w, 0, -1, w + ST + 8, riseAt, fallAt);
      check("R5 supply rise edge", riseAt, 1);
      check("R6 supply release edge", fallAt, w + ST + 1);
    end

    // R2: short button pulses are ignored
    for (int l = 1; l < DB; l++) begin
      runPattern(1, l, 0, -1, 0, -1, DB + ST + 10, riseAt, fallAt);
      check("R2 short press ignored", riseAt, 0);
    end

    // R3/R4: accepted presses of several lengths
    for (int l = DB; l <= DB + 3; l++) begin
      runPattern(1, l, 0, -1, 0, -1, l + DB + ST + 10, riseAt, fallAt);
      check("R3 press rise edge", riseAt, DB + 3);
      check("R4 press release edge", fallAt, l + DB + 3 + ST);
    end

    // R7: overlapping requests, release set by the later one
    runPattern(1, DB + 2, 3, 40, 0, -1, 40 + ST + 8, riseAt, fallAt);
    check("R7 overlap rise edge", riseAt, 3);
    check("R7 overlap release by supply", fallAt, 40 + ST + 1);
    runPattern(1, DB + 2, 1, 2, 0, -1, 2 * DB + ST + 14, riseAt, fallAt);
    check("R7 overlap release by button", fallAt, (DB + 2) + DB + 3 + ST);

    // R8: a request during the stretch restarts it, at every offset
    for (int k = 1; k <= ST; k++) begin
      runPattern(0, -1, 1, 2, 2 + k + 1, 2 + k + 1, 2 + k + ST + 10, riseAt, fallAt);
      check("R8 restart release edge", fallAt, (2 + k + 1) + ST + 1);
    end

    // R8: button press during the stretch after a supply fault
    runPattern(2 + 3, 2 + 3 + DB, 1, 2, 0, -1, 2 * DB + ST + 20, riseAt, fallAt);
    check("R8 button restart release edge", fallAt, 4 + (DB + 1) + DB + 3 + ST);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule